// File: doc/BRIEF.md
# Elapsed-Time Timebase Counters

This block keeps two free-running counters that measure time since the last cold reset. One counter approximates a count of 25 MHz cycles. It does not advance on every reference cycle. It advances once per 640 ns update tick, adding 16 each time, and it returns to zero once per second when it reaches 25,000,000. The other counter holds the number of whole seconds elapsed. It advances on the same tick that returns the cycle counter to zero.

A prescaler derives the update tick from the system clock. The divide ratio is the tick period divided by the system clock period, and both periods are parameters. The counters are read through a simple 32-bit register port with one word address per register. A read is captured on the clock edge that samples it, so the returned value is one consistent snapshot. Both counters are read-only, and a write to either one leaves it as it was.

Top module: `tbase_counters`

## Requirements
- R1: While `rst_n` is low at a clock edge, the prescaler, both counters and `bus_rdata` return to zero.
- R2: After reset, the cycle counter advances on every DIV-th clock edge, where DIV = TICK_PS / CLK_PERIOD_PS. It holds its value on all other edges.
- R3: Each advance adds CYC_STEP (16), so bits 3:0 of the cycle counter always read as zero.
- R4: When an advance would bring the cycle counter to CYC_WRAP (25,000,000) or above, it loads zero instead. Its value therefore never reaches CYC_WRAP.
- R5: The seconds counter adds one on exactly the tick that returns the cycle counter to zero, and holds its value at every other time.
- R6: A write (`bus_sel`=1, `bus_wr`=1) to word address 1 (cycle counter) or word address 0 (seconds counter) has no effect on either counter, whatever the write data.
- R7: A read (`bus_sel`=1, `bus_wr`=0) loads `bus_rdata` at that clock edge with the register's value from just before the edge. `bus_rdata` holds its value when no read is made.
- R8: A read of word address 2 or 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and bus clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 2 | Word address: 0 seconds, 1 cycle counter, 2-3 reserved |
| bus_wdata | input | 32 | Write data (always discarded) |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions assume that reset is held low for at least one clock edge before any property is evaluated. They also assume that the clock period divides the tick period exactly, so that DIV is a whole number. The bench meets both conditions. It holds reset for several edges at the start and in the middle of the run. It sets the clock period to exactly a quarter of the tick period, and it shortens the wrap value so that the seconds counter advances many times within the run. Bus accesses follow a fixed pattern of reads, idles, writes and reserved addresses, and each one is a single-cycle strobe.

// File: rtl/tbase_pkg.sv
// Shared constants and register addresses for the timebase counters.
// Assumes word addressing with one 32-bit register per address.
package tbase_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_SECONDS = 2'd0,
        A_CYCLES  = 2'd1,
        A_RSVD_2  = 2'd2,
        A_RSVD_3  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/tick_prescaler.sv
// Divides the system clock by DIV and emits a one-cycle tick on the last
// count of each period. Assumes DIV >= 1.
module tick_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] pre_q;

    // Count from 0 to LAST, then restart from zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                   pre_q <= pre_q + 1'b1;
    end

    assign tick = (pre_q == LAST);

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/cycle_counter.sv
// Approximate reference-cycle counter: adds STEP on each tick and loads
// zero instead of reaching WRAP. Flags the tick on which it wraps.
// Assumes STEP < WRAP and that WRAP fits in W bits.
module cycle_counter #(
    parameter int W    = 32,
    parameter int STEP = 16,
    parameter int WRAP = 25000000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cyc,
    output logic         wrap
);
    localparam logic [W-1:0] STEP_V = W'(STEP);
    localparam logic [W-1:0] WRAP_V = W'(WRAP);

    logic [W-1:0] next_v;

    assign next_v = cyc + STEP_V;
    assign wrap   = tick && (next_v >= WRAP_V);

    // Advance on tick, restarting from zero instead of reaching the wrap value.
    always_ff @(posedge clk) begin
        if (!rst_n)    cyc <= '0;
        else if (wrap) cyc <= '0;
        else if (tick) cyc <= next_v;
    end

    // R3
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc[3:0] == 4'd0);
    // R4
    cyc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc < WRAP_V);
    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cyc));
endmodule

// File: rtl/seconds_counter.sv
// Whole-seconds counter: adds one for every wrap pulse of the cycle counter.
// Assumes a 32-bit count never overflows during the device lifetime.
module seconds_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] secs
);
    // Count completed seconds.
    always_ff @(posedge clk) begin
        if (!rst_n)   secs <= '0;
        else if (inc) secs <= secs + 1'b1;
    end

    // R5
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(secs));
endmodule

// File: rtl/tbase_counters.sv
// Top of the timebase counters: prescaler, cycle counter, seconds counter
// and a registered read port. Both registers are read-only, so the write
// path is decoded only to be discarded. Assumes TICK_PS is a whole multiple
// of CLK_PERIOD_PS.
module tbase_counters
    import tbase_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 40000,
    parameter int TICK_PS       = 640000,
    parameter int CYC_STEP      = 16,
    parameter int CYC_WRAP      = 25000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    localparam int DIV = TICK_PS / CLK_PERIOD_PS;

    logic              tick;
    logic              wrap;
    logic [WORD_W-1:0] cyc_q;
    logic [WORD_W-1:0] sec_q;
    logic              rd_en;
    logic              wr_en;

    tick_prescaler #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    cycle_counter #(.W(WORD_W), .STEP(CYC_STEP), .WRAP(CYC_WRAP)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cyc   (cyc_q),
        .wrap  (wrap)
    );

    seconds_counter #(.W(WORD_W)) u_sec (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wrap),
        .secs  (sec_q)
    );

    assign rd_en = bus_sel && !bus_wr;
    assign wr_en = bus_sel &&  bus_wr;

    // Capture a snapshot of the addressed register on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            case (reg_addr_e'(bus_addr))
                A_SECONDS: bus_rdata <= sec_q;
                A_CYCLES:  bus_rdata <= cyc_q;
                default:   bus_rdata <= '0;
            endcase
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cyc_q == '0 && sec_q == '0 && bus_rdata == '0));
    // R5
    sec_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q != $past(sec_q)) |-> (cyc_q == '0 && $past(cyc_q) != '0));
    // R6
    write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tick && bus_wdata != '0) |=> ($stable(cyc_q) && $stable(sec_q)));
    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/tbase_counters_test.sv
`timescale 1ns/1ps
module tbase_counters_test;
    localparam int CLK_NS = 160;
    localparam int TICK_NS = 640;
    localparam int STEP = 16;
    localparam int WRAP = 320;
    localparam int DIV = TICK_NS / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_pre, m_cyc, m_sec;
    logic [31:0] m_rd;

    tbase_counters #(
        .CLK_PERIOD_PS(CLK_NS * 1000),
        .TICK_PS(TICK_NS * 1000),
        .CYC_STEP(STEP),
        .CYC_WRAP(WRAP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive inputs, step the reference model, then compare at the next negedge.
    task automatic run_cycle(input logic r, input logic s, input logic w,
                             input logic [1:0] a, input logic [31:0] d, input string tag);
        bit cyc_read;
        rst_n = r; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        cyc_read = r && s && !w && a == 2'd1;
        if (!r) begin
            m_pre = 0; m_cyc = 0; m_sec = 0; m_rd = '0;
        end else begin
            if (s && !w) m_rd = (a == 2'd0) ? 32'(m_sec) : (a == 2'd1) ? 32'(m_cyc) : 32'd0;
            if (m_pre == DIV - 1) begin
                m_pre = 0;
                if (m_cyc + STEP >= WRAP) begin m_cyc = 0; m_sec++; end
                else m_cyc += STEP;
            end else m_pre++;
        end
        @(negedge clk);
        check(bus_rdata, m_rd, tag);
        if (cyc_read) check({28'd0, bus_rdata[3:0]}, 32'd0, "R3 low bits");
    endtask

    initial begin
        rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        m_pre = 0; m_cyc = 0; m_sec = 0; m_rd = '0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) run_cycle(0, 1, 0, 2'd1, 0, "R1 reset");
        // Reset state seen through reads
        run_cycle(1, 1, 0, 2'd0, 0, "R1 seconds after reset");
        run_cycle(1, 1, 0, 2'd1, 0, "R1 cycles after reset");
        // Continuous cycle-counter reads across several wraps
        for (int i = 0; i < 200; i++) run_cycle(1, 1, 0, 2'd1, 0, "R2 R4 cycle count");
        // Mixed reads, idles and reserved addresses
        for (int i = 0; i < 300; i++) begin
            case (i % 5)
                0: run_cycle(1, 1, 0, 2'd0, 0, "R5 seconds");
                1: run_cycle(1, 1, 0, 2'd1, 0, "R4 cycle count");
                2: run_cycle(1, 0, 0, 2'd1, 0, "R7 hold when idle");
                3: run_cycle(1, 1, 0, 2'(2 + (i % 2)), 0, "R8 reserved reads zero");
                default: run_cycle(1, 0, 1, 2'd0, 32'hDEAD_BEEF, "R7 hold when idle");
            endcase
        end
        // Writes to both registers interleaved with reads
        for (int i = 0; i < 200; i++) begin
            case (i % 4)
                0: run_cycle(1, 1, 1, 2'd1, 32'hFFFF_FFF0, "R6 write cycles ignored");
                1: run_cycle(1, 1, 0, 2'd1, 0, "R6 cycles after write");
                2: run_cycle(1, 1, 1, 2'd0, 32'h0000_1234, "R6 write seconds ignored");
                default: run_cycle(1, 1, 0, 2'd0, 0, "R6 seconds after write");
            endcase
        end
        // Mid-run reset, then restart from zero
        for (int i = 0; i < 2; i++) run_cycle(0, 0, 0, 2'd0, 0, "R1 mid-run reset");
        for (int i = 0; i < 200; i++)
            run_cycle(1, 1, 0, 2'(i % 2), 0, "R1 R5 restart after reset");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule